// File: doc/BRIEF.md
# DMA Block Transfer Channel

A single DMA channel that moves data in whole blocks between a source address and a destination address. Software programs both addresses, a block length, a number of blocks, a byte or 16-bit word element size, an update mode for each address, and which side is the repeating block area. It then sets two enable bits. From then on, every activation request on the selected request line moves one complete block. Each element takes one cycle on a simple bus master port: a read and a write in the same cycle.

After each block, the block-area address is rewound to where that block started and the working length counter is reloaded. The opposite address keeps advancing. The block counter steps down by one. When the counter reaches zero, the channel clears its transfer enable, sets a done flag and raises its interrupt if the interrupt is enabled. A request that arrives while a block is running is remembered and starts the next block as soon as the current one ends.

Top module: `dma_blk_chan`

## Requirements
- R1: After reset, all registers read zero, no bus cycle is issued and `irq` is low.
- R2: Register map. 0 = source address. 1 = destination address. 2 = block length: working count in bits [7:0] and reload in bits [15:8]. 3 = block count (16 bits). 4 = control: source mode [1:0], destination mode [3:2], block-area side [4] (0 = source, 1 = destination), word size [5], request select [9:6], interrupt enable [10]. 5 = enables: transfer [0], master [1], done [2]. Every register reads back what was written.
- R3: Requests are taken and bus cycles are issued only while both the transfer and master enable bits are 1. A request seen with only one of them set moves nothing and leaves the block count unchanged.
- R4: One request moves exactly as many elements as the reload length, one per clock cycle. The channel then stays idle until the next request.
- R5: Address mode 01 increments, mode 10 decrements, and modes 00 and 11 hold the address. The step is 1 in byte mode and 2 in word mode.
- R6: After each block, the block-area address is restored to its value at the start of that block. The other address keeps its advanced value.
- R7: After each block, the working length equals the reload value and the block count is one lower.
- R8: When the block count reaches zero, the transfer enable reads 0, the done flag reads 1, the master enable is kept, and `irq` equals the interrupt enable bit.
- R9: A request that arrives during a block is held and runs one further block once the current block finishes.
- R10: Only the request line chosen by the select field activates the channel.
- R11: Register writes are ignored while a block is in progress.
- R12: A byte transfer writes the low byte read from the source. A word transfer writes the full 16 bits, with `mem_word` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| act_req | input | 16 | Activation request lines |
| mem_rd_en | output | 1 | Read cycle this clock |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_data | input | 16 | Read data, returned in the same cycle |
| mem_wr_en | output | 1 | Write cycle this clock |
| mem_wr_addr | output | 16 | Write address |
| mem_wr_data | output | 16 | Write data |
| mem_word | output | 1 | 1 = 16-bit element, 0 = byte |
| irq | output | 1 | Transfer-end interrupt |

## Verification
A wrong internal state shows up at the ports within one block of the fault. A mis-stepped address or a missed rewind corrupts the destination memory image, and the address read back after the block differs from the expected value. A length counter that reloads wrongly changes the number of write cycles seen for the very next request. A lost or duplicated pending request changes the block count read back after the request pair. An end-of-count fault shows in the enable register and on `irq` in the cycle after the last block.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
    typedef enum logic [1:0] {
        AM_HOLD  = 2'b00,
        AM_UP    = 2'b01,
        AM_DOWN  = 2'b10,
        AM_HOLD2 = 2'b11
    } amode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } chan_st_e;

    localparam logic [2:0] RI_SRC  = 3'd0;
    localparam logic [2:0] RI_DST  = 3'd1;
    localparam logic [2:0] RI_LEN  = 3'd2;
    localparam logic [2:0] RI_BCNT = 3'd3;
    localparam logic [2:0] RI_CTRL = 3'd4;
    localparam logic [2:0] RI_ENA  = 3'd5;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [1:0]        mode,
    input  logic              word,
    output logic [ADDR_W-1:0] nxt
);
    import dma_blk_pkg::*;

    logic [ADDR_W-1:0] step;

    always_comb begin
        step = word ? ADDR_W'(2) : ADDR_W'(1);
        case (amode_e'(mode))
            AM_UP:   nxt = cur + step;
            AM_DOWN: nxt = cur - step;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/dma_req_sel.sv
module dma_req_sel #(
    parameter int NREQ  = 16,
    parameter int SEL_W = 4
) (
    input  logic [NREQ-1:0]  req,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    logic [NREQ-1:0] match;

    for (genvar i = 0; i < NREQ; i++) begin : g_line
        assign match[i] = req[i] && (sel == SEL_W'(i));
    end

    assign hit = |match;
endmodule

// File: rtl/dma_blk_chan.sv
module dma_blk_chan #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int BCNT_W = 16,
    parameter int NREQ   = 16,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NREQ-1:0]   act_req,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [15:0]       mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [15:0]       mem_wr_data,
    output logic              mem_word,
    output logic              irq
);
    import dma_blk_pkg::*;

    localparam int SEL_W  = $clog2(NREQ);
    localparam int CF_SEL = 6;
    localparam int CF_IE  = CF_SEL + SEL_W;

    typedef struct packed {
        chan_st_e          st;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  len;
        logic [CNT_W-1:0]  rld;
        logic [BCNT_W-1:0] bcnt;
        logic [1:0]        smode;
        logic [1:0]        dmode;
        logic              bdir;
        logic              word;
        logic [SEL_W-1:0]  sel;
        logic              ie;
        logic              xen;
        logic              men;
        logic              done;
        logic              pend;
    } chan_t;

    chan_t r_q, r_d;

    logic [ADDR_W-1:0] src_nx, dst_nx;
    logic              req_hit;
    logic              armed, busy, start, last;

    dma_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
        .cur(r_q.src), .mode(r_q.smode), .word(r_q.word), .nxt(src_nx)
    );
    dma_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
        .cur(r_q.dst), .mode(r_q.dmode), .word(r_q.word), .nxt(dst_nx)
    );
    dma_req_sel #(.NREQ(NREQ), .SEL_W(SEL_W)) u_req (
        .req(act_req), .sel(r_q.sel), .hit(req_hit)
    );

    assign armed = r_q.xen && r_q.men;
    assign busy  = (r_q.st == ST_RUN);
    assign last  = (r_q.len <= CNT_W'(1));
    assign start = !busy && armed && r_q.pend && (r_q.bcnt != '0) && !reg_we;

    always_comb begin
        r_d = r_q;
        r_d.pend = armed && ((r_q.pend && !start) || req_hit);

        if (reg_we && !busy) begin
            case (reg_addr)
                RI_SRC:  r_d.src = reg_wdata[ADDR_W-1:0];
                RI_DST:  r_d.dst = reg_wdata[ADDR_W-1:0];
                RI_LEN: begin
                    r_d.len = reg_wdata[CNT_W-1:0];
                    r_d.rld = reg_wdata[2*CNT_W-1:CNT_W];
                end
                RI_BCNT: r_d.bcnt = reg_wdata[BCNT_W-1:0];
                RI_CTRL: begin
                    r_d.smode = reg_wdata[1:0];
                    r_d.dmode = reg_wdata[3:2];
                    r_d.bdir  = reg_wdata[4];
                    r_d.word  = reg_wdata[5];
                    r_d.sel   = reg_wdata[CF_SEL +: SEL_W];
                    r_d.ie    = reg_wdata[CF_IE];
                end
                RI_ENA: begin
                    r_d.xen  = reg_wdata[0];
                    r_d.men  = reg_wdata[1];
                    r_d.done = reg_wdata[2];
                end
                default: ;
            endcase
        end

        if (start) begin
            r_d.st   = ST_RUN;
            r_d.base = r_q.bdir ? r_q.dst : r_q.src;
        end

        if (busy) begin
            r_d.src = src_nx;
            r_d.dst = dst_nx;
            if (last) begin
                r_d.st   = ST_IDLE;
                r_d.len  = r_q.rld;
                r_d.bcnt = r_q.bcnt - BCNT_W'(1);
                if (r_q.bdir) r_d.dst = r_q.base;
                else          r_d.src = r_q.base;
                if (r_q.bcnt == BCNT_W'(1)) begin
                    r_d.xen  = 1'b0;
                    r_d.done = 1'b1;
                    r_d.pend = 1'b0;
                end
            end else begin
                r_d.len = r_q.len - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RI_SRC:  reg_rdata = REG_W'(r_q.src);
            RI_DST:  reg_rdata = REG_W'(r_q.dst);
            RI_LEN:  reg_rdata = REG_W'({r_q.rld, r_q.len});
            RI_BCNT: reg_rdata = REG_W'(r_q.bcnt);
            RI_CTRL: reg_rdata = REG_W'({r_q.ie, r_q.sel, r_q.word, r_q.bdir,
                                         r_q.dmode, r_q.smode});
            RI_ENA:  reg_rdata = REG_W'({r_q.done, r_q.men, r_q.xen});
            default: reg_rdata = '0;
        endcase
    end

    assign mem_rd_en   = busy;
    assign mem_rd_addr = r_q.src;
    assign mem_wr_en   = busy;
    assign mem_wr_addr = r_q.dst;
    assign mem_wr_data = r_q.word ? mem_rd_data : {8'h00, mem_rd_data[7:0]};
    assign mem_word    = r_q.word;
    assign irq         = r_q.done && r_q.ie;

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

    logic              obs_xen, obs_men, obs_done;
    logic [BCNT_W-1:0] obs_bcnt;
    logic [CNT_W-1:0]  obs_rld;
    assign obs_xen  = r_q.xen;
    assign obs_men  = r_q.men;
    assign obs_done = r_q.done;
    assign obs_bcnt = r_q.bcnt;
    assign obs_rld  = r_q.rld;
endmodule

// File: rtl/dma_blk_chan_chk.sv
module dma_blk_chan_chk #(
    parameter int CNT_W  = 8,
    parameter int BCNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              busy,
    input logic              mem_wr_en,
    input logic              xen,
    input logic              men,
    input logic              done,
    input logic              irq,
    input logic [CNT_W-1:0]  rld,
    input logic [BCNT_W-1:0] bcnt
);
    a_r3_bus_needs_both_enables: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (xen && men));

    a_r8_done_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !$past(reg_we)) |-> !xen);

    a_r8_irq_rises_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(busy) || $past(reg_we)));

    a_r7_count_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (bcnt == $past(bcnt) || bcnt == $past(bcnt) - BCNT_W'(1)));

    a_r3_idle_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !reg_we) |=> $stable(bcnt));

    a_r11_reload_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rld));
endmodule

bind dma_blk_chan dma_blk_chan_chk #(.CNT_W(CNT_W), .BCNT_W(BCNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .busy(busy),
    .mem_wr_en(mem_wr_en), .xen(obs_xen), .men(obs_men), .done(obs_done),
    .irq(irq), .rld(obs_rld), .bcnt(obs_bcnt)
);

// File: tb/tb_dma_blk_chan.sv
module tb_dma_blk_chan;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] act_req = '0;
    logic        mem_rd_en, mem_wr_en, mem_word, irq;
    logic [15:0] mem_rd_addr, mem_wr_addr, mem_wr_data, mem_rd_data;

    logic [7:0]  mem [256];
    logic [7:0]  sh  [256];
    logic        fill_go = 1'b0;
    int          fill_gen = 0;
    int          n_chk = 0, n_bad = 0, n_xfer = 0;

    always #(CLK_P/2) clk = ~clk;

    dma_blk_chan dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .act_req(act_req),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_word(mem_word), .irq(irq)
    );

    function automatic logic [7:0] fill_val(input int i, input int g);
        return 8'((i * 73 + g * 29 + 5) ^ (g << 3));
    endfunction

    assign mem_rd_data = {mem[8'(mem_rd_addr + 16'd1)], mem[mem_rd_addr[7:0]]};

    always @(posedge clk) begin
        if (fill_go) begin
            for (int i = 0; i < 256; i++) mem[i] <= fill_val(i, fill_gen);
        end else if (mem_wr_en) begin
            mem[mem_wr_addr[7:0]] <= mem_wr_data[7:0];
            if (mem_word) mem[8'(mem_wr_addr + 16'd1)] <= mem_wr_data[15:8];
        end
        if (rst_n && mem_wr_en) n_xfer <= n_xfer + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        act_req[line] = 1'b1;
        @(negedge clk);
        act_req = '0;
    endtask

    task automatic fill(input int g);
        @(negedge clk);
        fill_gen = g; fill_go = 1'b1;
        @(negedge clk);
        fill_go = 1'b0;
        for (int i = 0; i < 256; i++) sh[i] = fill_val(i, g);
    endtask

    function automatic logic [15:0] stp(input logic [1:0] m, input logic w);
        logic [15:0] s;
        s = w ? 16'd2 : 16'd1;
        if (m == 2'b01) return s;
        if (m == 2'b10) return -s;
        return 16'd0;
    endfunction

    function automatic logic [31:0] ctrl_word(input logic [1:0] sm, input logic [1:0] dm,
                                              input logic bd, input logic w,
                                              input logic [3:0] sel, input logic ie);
        return {21'd0, ie, sel, w, bd, dm, sm};
    endfunction

    // Reference model of one block on the shadow memory.
    task automatic model_block(inout logic [15:0] s, inout logic [15:0] d, input int len,
                               input logic [1:0] sm, input logic [1:0] dm,
                               input logic bd, input logic w);
        logic [15:0] s0, d0;
        s0 = s; d0 = d;
        for (int i = 0; i < len; i++) begin
            logic [7:0] lo, hi;
            lo = sh[s[7:0]];
            hi = sh[8'(s + 16'd1)];
            sh[d[7:0]] = lo;
            if (w) sh[8'(d + 16'd1)] = hi;
            s = s + stp(sm, w);
            d = d + stp(dm, w);
        end
        if (bd) d = d0; else s = s0;
    endtask

    task automatic run_job(input logic [15:0] s_in, input logic [15:0] d_in, input int len,
                           input int cnt, input logic [1:0] sm, input logic [1:0] dm,
                           input logic bd, input logic w, input logic [3:0] sel,
                           input logic ie, input int g);
        logic [31:0] v;
        logic [15:0] es, ed;
        int x0, bad;
        fill(g);
        wr_reg(3'd5, 32'd0);
        wr_reg(3'd0, {16'd0, s_in});
        wr_reg(3'd1, {16'd0, d_in});
        wr_reg(3'd2, 32'(len * 257));
        wr_reg(3'd3, 32'(cnt));
        wr_reg(3'd4, ctrl_word(sm, dm, bd, w, sel, ie));
        wr_reg(3'd5, 32'd3);
        es = s_in; ed = d_in;
        for (int b = 0; b < cnt; b++) begin
            x0 = n_xfer;
            pulse(sel);
            repeat (len + 6) @(negedge clk);
            chk("R4 elements per request", 32'(n_xfer - x0), 32'(len));
            model_block(es, ed, len, sm, dm, bd, w);
            rd_reg(3'd2, v);
            chk("R7 length reloaded", v, 32'(len * 257));
            rd_reg(3'd3, v);
            chk("R7 block count", v, 32'(cnt - 1 - b));
            rd_reg(3'd0, v);
            chk("R5 R6 source address", v, {16'd0, es});
            rd_reg(3'd1, v);
            chk("R5 R6 destination address", v, {16'd0, ed});
        end
        rd_reg(3'd5, v);
        chk("R8 enables at end", v, 32'd6);
        chk("R8 irq follows enable", {31'd0, irq}, {31'd0, ie});
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== sh[i]) bad++;
        chk("R12 R5 memory image", 32'(bad), 32'd0);
        wr_reg(3'd5, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int x0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd_reg(3'(a), v);
            chk("R1 register reset", v, 32'd0);
        end
        chk("R1 irq reset", {31'd0, irq}, 32'd0);
        chk("R1 no bus cycles", 32'(n_xfer), 32'd0);

        // R2 readback
        wr_reg(3'd4, ctrl_word(2'b10, 2'b01, 1'b1, 1'b1, 4'd9, 1'b1));
        rd_reg(3'd4, v);
        chk("R2 control readback", v, ctrl_word(2'b10, 2'b01, 1'b1, 1'b1, 4'd9, 1'b1));
        wr_reg(3'd0, 32'h0000_ABCD);
        rd_reg(3'd0, v);
        chk("R2 source readback", v, 32'h0000_ABCD);

        // R3 single enable does nothing
        wr_reg(3'd2, 32'h0404);
        wr_reg(3'd3, 32'd2);
        wr_reg(3'd4, ctrl_word(2'b01, 2'b01, 1'b0, 1'b0, 4'd3, 1'b0));
        wr_reg(3'd5, 32'd1);
        x0 = n_xfer;
        pulse(3);
        repeat (8) @(negedge clk);
        chk("R3 transfer enable only", 32'(n_xfer - x0), 32'd0);
        wr_reg(3'd5, 32'd2);
        pulse(3);
        repeat (8) @(negedge clk);
        chk("R3 master enable only", 32'(n_xfer - x0), 32'd0);
        rd_reg(3'd3, v);
        chk("R3 count unchanged", v, 32'd2);

        // R10 wrong line ignored
        wr_reg(3'd5, 32'd3);
        pulse(7);
        repeat (8) @(negedge clk);
        chk("R10 other line ignored", 32'(n_xfer - x0), 32'd0);
        pulse(3);
        repeat (10) @(negedge clk);
        chk("R10 selected line runs", 32'(n_xfer - x0), 32'd4);

        // R9 request during a block is held
        wr_reg(3'd5, 32'd0);
        wr_reg(3'd2, 32'h0606);
        wr_reg(3'd3, 32'd5);
        wr_reg(3'd5, 32'd3);
        x0 = n_xfer;
        pulse(3);
        repeat (2) @(negedge clk);
        pulse(3);
        repeat (20) @(negedge clk);
        chk("R9 two blocks moved", 32'(n_xfer - x0), 32'd12);
        rd_reg(3'd3, v);
        chk("R9 count down by two", v, 32'd3);

        // R11 writes ignored during a block
        wr_reg(3'd5, 32'd0);
        wr_reg(3'd0, 32'h0010);
        wr_reg(3'd2, 32'h0808);
        wr_reg(3'd3, 32'd2);
        wr_reg(3'd5, 32'd3);
        pulse(3);
        repeat (2) @(negedge clk);
        wr_reg(3'd0, 32'h0055);
        wr_reg(3'd3, 32'd9);
        repeat (10) @(negedge clk);
        rd_reg(3'd0, v);
        chk("R11 source write ignored", v, 32'h0010);
        rd_reg(3'd3, v);
        chk("R11 count write ignored", v, 32'd1);
        wr_reg(3'd5, 32'd0);

        // Directed corner jobs: word decrement, byte fixed source, block area on each side
        run_job(16'h0040, 16'h00A0, 4, 2, 2'b10, 2'b01, 1'b0, 1'b1, 4'd2, 1'b1, 1);
        run_job(16'h0005, 16'h0080, 3, 3, 2'b00, 2'b01, 1'b1, 1'b0, 4'd11, 1'b0, 2);
        run_job(16'h0030, 16'h0090, 1, 2, 2'b01, 2'b11, 1'b0, 1'b0, 4'd0, 1'b1, 3);

        // Constrained random jobs
        for (int k = 0; k < 8; k++) begin
            run_job(16'($urandom_range(0, 255)), 16'($urandom_range(0, 255)),
                    $urandom_range(1, 8), $urandom_range(1, 3),
                    2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 10 + k);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule